// File: doc/BRIEF.md
# Interrupt Line Collector with Memory-Write Delivery

This block gathers twenty-four interrupt request lines and turns their events into memory-write messages that a processor snoops. Lines 0 to 15 come from internal active-high sources. Lines 16 to 23 come from shared active-low board pins. Four of those shared lines, 16 to 19, can also be pulled by serial-decoded request inputs and by virtual wires. The virtual wires are raised and lowered by incoming PCI assert and deassert messages for INTA to INTD. Each line has its own polarity, trigger mode and mask bit, and its own 32-bit address and data pair.

When a line sees an event, its request bit is updated first. The delivery engine then raises a bus request and waits for the grant, which stands for the point where upstream buffers have been drained. Only after the grant does it present the address and data of the chosen line on a valid/ready write port. Pending lines are served one at a time, and the lowest line number goes first.

Top module: `irq_msg_unit`

## Requirements
- R1: After reset, `irr_o` is all zero, `bus_req_o` is 0 and `msg_valid_o` is 0.
- R2: A line's normalised level is its raw level XOR its `cfg_active_low_i` bit. A change of that bit acts like a change of the line and takes effect at the next clock edge.
- R3: In edge mode (`cfg_level_i` bit 0), only an inactive-to-active transition sets the request bit and schedules one message. Holding the line active, or returning it to inactive, has no effect.
- R4: In level mode (`cfg_level_i` bit 1), the request bit follows the normalised level after every change. A change to active schedules one message, and a change to inactive issues none.
- R5: Line 16+k is active-low. It is driven by pin k for k = 0..7. For k = 0..3 it is also driven by serial input k and by virtual wire k. Any asserted source asserts the line.
- R6: A PCI message with `intx_valid_i`=1 sets virtual wire `intx_sel_i` (0=INTA .. 3=INTD) when `intx_assert_i`=1, and clears it when `intx_assert_i`=0.
- R7: A change on a pin, direct or serial input passes two synchroniser stages. It shows in `irr_o` after the third rising clock edge. A virtual-wire message shows after the second edge.
- R8: `bus_req_o` rises on the edge after an unmasked line becomes pending. `msg_valid_o` rises only after `bus_gnt_i` is seen. The request is held until the write completes, and it is low in the cycle that follows.
- R9: The message for line i carries `cfg_addr_i[32*i +: 32]` and `cfg_data_i[32*i +: 32]`. Address, data and valid stay stable until `msg_ready_i` is seen.
- R10: When several unmasked lines are pending, the lowest line number is delivered first.
- R11: Further events on a line whose message is still pending produce no extra message.
- R12: A masked line still updates its request bit, but no message or bus request is issued for it until it is unmasked.
- R13: In edge mode, a line's request bit is cleared when its message write completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| irq_direct_i | input | 16 | Internal active-high sources, lines 0..15 |
| pirq_pin_ni | input | 8 | Shared active-low pins, lines 16..23 |
| pirq_ser_ni | input | 4 | Serial-decoded active-low requests, lines 16..19 |
| intx_valid_i | input | 1 | PCI interrupt message strobe |
| intx_assert_i | input | 1 | 1 = assert, 0 = deassert the selected virtual wire |
| intx_sel_i | input | 2 | Virtual wire select, 0=INTA .. 3=INTD |
| cfg_active_low_i | input | 24 | Per-line polarity inversion |
| cfg_level_i | input | 24 | Per-line trigger mode, 1 = level |
| cfg_mask_i | input | 24 | Per-line message mask |
| cfg_addr_i | input | 768 | Per-line message address, 32 bits per line |
| cfg_data_i | input | 768 | Per-line message data, 32 bits per line |
| irr_o | output | 24 | Request-register bits |
| bus_req_o | output | 1 | Flushing bus request |
| bus_gnt_i | input | 1 | Bus grant |
| msg_valid_o | output | 1 | Message write valid |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |
| msg_ready_i | input | 1 | Message write accepted |

## Verification
On every cycle, the assertions check the handshake order: valid only under a request, valid only after a grant, hold while not ready, and the request dropped after completion. They also check that the picked line is the lowest eligible one, and that request and pending bits rise only with an active line. What only the bench scenarios can show is the exact latency through the synchronisers, the effect of polarity and of each source on a given line, and the level-mode clearing. The scenarios also cover coalescing and masking across a long wait, and that each message carries the right line's address and data.

// File: rtl/irq_msg_pkg.sv
`timescale 1ns/1ps
// Shared types for the interrupt message delivery unit.
// Assumes: a single clock domain for all consumers of these types.
package irq_msg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_SEND = 2'd2,
        ST_GAP  = 2'd3
    } dlv_state_e;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
// Two-stage synchroniser for a vector of asynchronous inputs.
// Assumes: each bit is independent; RST_VAL is the idle level of the inputs.
module irq_sync #(
    parameter int          WIDTH   = 8,
    parameter logic [63:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the inputs through two flops.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stage1_q <= RST_VAL[WIDTH-1:0];
            stage2_q <= RST_VAL[WIDTH-1:0];
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/irq_intx_vwire.sv
`timescale 1ns/1ps
// Virtual level wires driven by received PCI INTx assert/deassert messages.
// Assumes: messages arrive synchronous to clk_i, at most one per cycle.
module irq_intx_vwire #(
    parameter int NUM_VW = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      valid_i,
    input  logic                      assert_i,
    input  logic [$clog2(NUM_VW)-1:0] sel_i,
    output logic [NUM_VW-1:0]         vw_o
);
    logic [NUM_VW-1:0] vw_q;

    // Set or clear the addressed wire on each message.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            vw_q <= '0;
        end else if (valid_i) begin
            vw_q[sel_i] <= assert_i;
        end
    end

    assign vw_o = vw_q;

    // R6: a message changes only the selected wire.
    for (genvar g = 0; g < NUM_VW; g++) begin : g_chk
        assert_vw_untouched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(valid_i) && ($past(sel_i) != g[$clog2(NUM_VW)-1:0])) |-> $stable(vw_q[g]));
    end
endmodule

// File: rtl/irq_line_detect.sv
`timescale 1ns/1ps
// Per-line event detector: edge or level trigger, request bit and pending bit.
// Assumes: act_i is already synchronised and polarity-normalised (1 = active).
module irq_line_detect #(
    parameter int NUM = 24
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NUM-1:0] act_i,
    input  logic [NUM-1:0] level_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] irr_o,
    output logic [NUM-1:0] pend_o
);
    logic [NUM-1:0] act_q;
    logic [NUM-1:0] irr_q;
    logic [NUM-1:0] pend_q;
    logic [NUM-1:0] rise;
    logic [NUM-1:0] chg;

    // Find rising and any-change events against last cycle's level.
    always_comb begin
        rise = act_i & ~act_q;
        chg  = act_i ^ act_q;
    end

    // Update history, request and pending bits.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            act_q  <= '0;
            irr_q  <= '0;
            pend_q <= '0;
        end else begin
            act_q  <= act_i;
            pend_q <= (pend_q & ~clr_i) | rise;
            for (int i = 0; i < NUM; i++) begin
                if (level_i[i]) begin
                    if (chg[i]) irr_q[i] <= act_i[i];
                end else begin
                    irr_q[i] <= (irr_q[i] & ~clr_i[i]) | rise[i];
                end
            end
        end
    end

    assign irr_o  = irr_q;
    assign pend_o = pend_q;

    for (genvar g = 0; g < NUM; g++) begin : g_chk
        // R3: in edge mode a request bit rises only with an active line.
        assert_edge_irr_active_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!level_i[g] && $rose(irr_q[g])) |-> act_q[g]);
        // R11: a pending delivery starts only from an active line.
        assert_pend_active_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(pend_q[g]) |-> act_q[g]);
    end
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
// Fixed-priority picker: returns the lowest-numbered set bit.
// Assumes: idx_o is meaningful only while any_o is high.
module irq_prio_pick #(
    parameter int NUM   = 24,
    parameter int IDX_W = $clog2(NUM)
) (
    input  logic [NUM-1:0]   elig_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        any_o = |elig_i;
        idx_o = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (elig_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_msg_fsm.sv
`timescale 1ns/1ps
// Delivery sequencer: request bus, wait grant, write message, drop request.
// Assumes: the grant stays high until the request falls.
module irq_msg_fsm import irq_msg_pkg::*; #(
    parameter int IDX_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             any_elig_i,
    input  logic [IDX_W-1:0] pick_idx_i,
    input  logic             bus_gnt_i,
    input  logic             msg_ready_i,
    output logic             load_o,
    output logic             done_o,
    output logic [IDX_W-1:0] cur_idx_o,
    output logic             bus_req_o,
    output logic             msg_valid_o
);
    dlv_state_e       state_q, state_d;
    logic [IDX_W-1:0] cur_idx_q;

    // Next-state selection for one delivery.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_elig_i)  state_d = ST_REQ;
            ST_REQ:  if (bus_gnt_i)   state_d = ST_SEND;
            ST_SEND: if (msg_ready_i) state_d = ST_GAP;
            ST_GAP:                   state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Register state and the line being served.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q   <= ST_IDLE;
            cur_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (load_o) cur_idx_q <= pick_idx_i;
        end
    end

    assign load_o      = (state_q == ST_IDLE) && any_elig_i;
    assign done_o      = (state_q == ST_SEND) && msg_ready_i;
    assign cur_idx_o   = cur_idx_q;
    assign bus_req_o   = (state_q == ST_REQ) || (state_q == ST_SEND);
    assign msg_valid_o = (state_q == ST_SEND);

    // R8: a write is only presented while the bus is requested.
    assert_valid_under_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_valid_o |-> bus_req_o);
    // R8: a write starts only after a grant was seen.
    assert_valid_after_gnt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(msg_valid_o) |-> $past(bus_gnt_i));
    // R8: the request drops for a cycle after completion.
    assert_req_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (msg_valid_o && msg_ready_i) |=> !bus_req_o);
    // R9: valid and line are held while the write waits.
    assert_hold_until_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(cur_idx_q)));
endmodule

// File: rtl/irq_msg_unit.sv
`timescale 1ns/1ps
// Interrupt message delivery unit: collects request lines, detects events
// and delivers one memory-write message per event after a bus grant.
// Assumes: configuration inputs are quasi-static; pins and serial inputs
// are asynchronous; INTx messages are synchronous to clk_i.
module irq_msg_unit import irq_msg_pkg::*; #(
    parameter int NUM_DIRECT = 16,
    parameter int NUM_PIN    = 8,
    parameter int NUM_SER    = 4,
    parameter int NUM_VW     = 4,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic [NUM_DIRECT-1:0]                 irq_direct_i,
    input  logic [NUM_PIN-1:0]                    pirq_pin_ni,
    input  logic [NUM_SER-1:0]                    pirq_ser_ni,
    input  logic                                  intx_valid_i,
    input  logic                                  intx_assert_i,
    input  logic [$clog2(NUM_VW)-1:0]             intx_sel_i,
    input  logic [NUM_DIRECT+NUM_PIN-1:0]         cfg_active_low_i,
    input  logic [NUM_DIRECT+NUM_PIN-1:0]         cfg_level_i,
    input  logic [NUM_DIRECT+NUM_PIN-1:0]         cfg_mask_i,
    input  logic [(NUM_DIRECT+NUM_PIN)*ADDR_W-1:0] cfg_addr_i,
    input  logic [(NUM_DIRECT+NUM_PIN)*DATA_W-1:0] cfg_data_i,
    output logic [NUM_DIRECT+NUM_PIN-1:0]         irr_o,
    output logic                                  bus_req_o,
    input  logic                                  bus_gnt_i,
    output logic                                  msg_valid_o,
    output logic [ADDR_W-1:0]                     msg_addr_o,
    output logic [DATA_W-1:0]                     msg_data_o,
    input  logic                                  msg_ready_i
);
    localparam int NUM_LINES = NUM_DIRECT + NUM_PIN;
    localparam int IDX_W     = $clog2(NUM_LINES);

    logic [NUM_DIRECT-1:0] direct_s;
    logic [NUM_PIN-1:0]    pin_s_n;
    logic [NUM_SER-1:0]    ser_s_n;
    logic [NUM_VW-1:0]     vw;
    logic [NUM_LINES-1:0]  raw;
    logic [NUM_LINES-1:0]  act;
    logic [NUM_LINES-1:0]  pend;
    logic [NUM_LINES-1:0]  elig;
    logic [NUM_LINES-1:0]  clr;
    logic                  pick_any;
    logic [IDX_W-1:0]      pick_idx;
    logic                  load;
    logic                  done;
    logic [IDX_W-1:0]      cur_idx;
    logic [ADDR_W-1:0]     addr_q;
    logic [DATA_W-1:0]     data_q;

    irq_sync #(.WIDTH(NUM_DIRECT), .RST_VAL('0)) u_sync_direct (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_direct_i), .q_o(direct_s));
    irq_sync #(.WIDTH(NUM_PIN), .RST_VAL('1)) u_sync_pin (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pirq_pin_ni), .q_o(pin_s_n));
    irq_sync #(.WIDTH(NUM_SER), .RST_VAL('1)) u_sync_ser (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pirq_ser_ni), .q_o(ser_s_n));

    irq_intx_vwire #(.NUM_VW(NUM_VW)) u_vwire (
        .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(intx_valid_i),
        .assert_i(intx_assert_i), .sel_i(intx_sel_i), .vw_o(vw));

    // Route internal sources straight to the low lines.
    for (genvar g = 0; g < NUM_DIRECT; g++) begin : g_direct
        assign raw[g] = direct_s[g];
    end

    // Combine the shared active-low sources onto the high lines.
    for (genvar k = 0; k < NUM_PIN; k++) begin : g_shared
        logic ser_n;
        logic vw_on;
        if (k < NUM_SER) begin : g_ser
            assign ser_n = ser_s_n[k];
        end else begin : g_noser
            assign ser_n = 1'b1;
        end
        if (k < NUM_VW) begin : g_vw
            assign vw_on = vw[k];
        end else begin : g_novw
            assign vw_on = 1'b0;
        end
        assign raw[NUM_DIRECT+k] = pin_s_n[k] & ser_n & ~vw_on;
    end

    // Normalise polarity so that 1 means active.
    assign act = raw ^ cfg_active_low_i;

    irq_line_detect #(.NUM(NUM_LINES)) u_detect (
        .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .level_i(cfg_level_i),
        .clr_i(clr), .irr_o(irr_o), .pend_o(pend));

    assign elig = pend & ~cfg_mask_i;

    irq_prio_pick #(.NUM(NUM_LINES), .IDX_W(IDX_W)) u_pick (
        .elig_i(elig), .any_o(pick_any), .idx_o(pick_idx));

    irq_msg_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .any_elig_i(pick_any),
        .pick_idx_i(pick_idx), .bus_gnt_i(bus_gnt_i), .msg_ready_i(msg_ready_i),
        .load_o(load), .done_o(done), .cur_idx_o(cur_idx),
        .bus_req_o(bus_req_o), .msg_valid_o(msg_valid_o));

    // Clear the served line's pending bit when its write completes.
    always_comb begin
        clr = '0;
        if (done) clr[cur_idx] = 1'b1;
    end

    // Capture the chosen line's address and data at selection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (load) begin
            addr_q <= cfg_addr_i[pick_idx*ADDR_W +: ADDR_W];
            data_q <= cfg_data_i[pick_idx*DATA_W +: DATA_W];
        end
    end

    assign msg_addr_o = addr_q;
    assign msg_data_o = data_q;

    // R10: the picked line is eligible and no lower line is.
    assert_pick_lowest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pick_any |-> (elig[pick_idx] &&
                      ((elig & ~({NUM_LINES{1'b1}} << pick_idx)) == '0)));
    // R9: address and data hold across a waiting write.
    assert_payload_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (msg_valid_o && $past(msg_valid_o)) |-> ($stable(msg_addr_o) && $stable(msg_data_o)));
    // R12: a masked line is never chosen for delivery.
    assert_masked_not_loaded_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load |-> !cfg_mask_i[pick_idx]);
endmodule

// File: tb/irq_msg_unit_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the stimulus pushes expected messages, a monitor pops
// and compares them at each completed write.
module irq_msg_unit_bench;
    localparam int NL = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       direct = '0;
    logic [7:0]        pin_n = '1;
    logic [3:0]        ser_n = '1;
    logic              intx_valid = 1'b0;
    logic              intx_assert = 1'b0;
    logic [1:0]        intx_sel = '0;
    logic [NL-1:0]     pol = {8'hFF, 16'h0000};
    logic [NL-1:0]     level = '0;
    logic [NL-1:0]     mask = '0;
    logic [NL*32-1:0]  cfg_addr;
    logic [NL*32-1:0]  cfg_data;
    logic [NL-1:0]     irr;
    logic              bus_req;
    logic              bus_gnt = 1'b0;
    logic              msg_valid;
    logic [31:0]       msg_addr;
    logic [31:0]       msg_data;
    logic              msg_ready = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int ready_lat = 0;
    int vcnt = 0;
    bit finished = 1'b0;
    logic [63:0] exp_q[$];
    logic        prev_wait = 1'b0;
    logic [63:0] prev_msg = '0;

    irq_msg_unit u_irq_msg_unit (
        .clk_i(clk), .rst_ni(rst_n), .irq_direct_i(direct), .pirq_pin_ni(pin_n),
        .pirq_ser_ni(ser_n), .intx_valid_i(intx_valid), .intx_assert_i(intx_assert),
        .intx_sel_i(intx_sel), .cfg_active_low_i(pol), .cfg_level_i(level),
        .cfg_mask_i(mask), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
        .irr_o(irr), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
        .msg_valid_o(msg_valid), .msg_addr_o(msg_addr), .msg_data_o(msg_data),
        .msg_ready_i(msg_ready));

    always #2.5 clk = ~clk;

    function automatic logic [63:0] exp_msg(input int line);
        return {32'h4000_0000 + 32'(line) * 32'h10, 32'h0000_A500 + 32'(line)};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_line(input int line);
        exp_q.push_back(exp_msg(line));
    endtask

    task automatic intx_msg(input logic [1:0] sel, input logic on);
        intx_valid = 1'b1; intx_sel = sel; intx_assert = on;
        cyc(1);
        intx_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 300 && exp_q.size() != 0; i++) cyc(1);
        cyc(10);
        check(req, 64'(exp_q.size()), 64'd0);
    endtask

    // Monitor: bus grant, ready pacing and scoreboard comparison.
    always @(negedge clk) begin
        if (rst_n) begin
            logic rdy;
            if (msg_valid && !bus_req) check("R8 valid without request", 64'd1, 64'd0);
            if (prev_wait) check("R9 held payload", {msg_valid, msg_addr, msg_data} , {1'b1, prev_msg});
            vcnt = msg_valid ? vcnt + 1 : 0;
            rdy = msg_valid && (vcnt > ready_lat);
            prev_wait = msg_valid && !rdy;
            prev_msg  = {msg_addr, msg_data};
            if (rdy) begin
                if (exp_q.size() == 0) check("R11/R12 unexpected message", {msg_addr, msg_data}, 64'd0);
                else check("R9 message payload", {msg_addr, msg_data}, exp_q.pop_front());
            end
            msg_ready <= rdy;
            bus_gnt   <= bus_req;
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) begin
            logic [63:0] m;
            m = exp_msg(i);
            cfg_addr[i*32 +: 32] = m[63:32];
            cfg_data[i*32 +: 32] = m[31:0];
        end
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        check("R1 irr after reset", 64'(irr), 64'd0);
        check("R1 req/valid after reset", {62'd0, bus_req, msg_valid}, 64'd0);

        // R3/R7/R8/R13: edge on line 4 with exact timing.
        direct[4] = 1'b1; expect_line(4);
        cyc(2);
        check("R7 irr not yet after two edges", 64'(irr[4]), 64'd0);
        cyc(1);
        check("R7 irr after third edge", 64'(irr[4]), 64'd1);
        cyc(1);
        check("R8 request raised, no valid yet", {62'd0, bus_req, msg_valid}, 64'b10);
        cyc(1);
        check("R8 valid after grant", 64'(msg_valid), 64'd1);
        cyc(1);
        check("R8 request dropped after write", 64'(bus_req), 64'd0);
        check("R13 edge irr cleared on completion", 64'(irr[4]), 64'd0);
        cyc(20);
        check("R3 held level gives no second message", 64'(exp_q.size()), 64'd0);
        direct[4] = 1'b0;
        cyc(10);
        check("R3 inactive edge leaves irr clear", 64'(irr[4]), 64'd0);

        // R2: polarity flip behaves as a line change.
        pol[7] = 1'b1; expect_line(7);
        cyc(1);
        check("R2 inversion activates line", 64'(irr[7]), 64'd1);
        drain("R2 inverted line delivered");
        direct[7] = 1'b1; cyc(10);
        direct[7] = 1'b0; expect_line(7);
        drain("R2 low level on inverted line delivers");
        pol[7] = 1'b0;
        cyc(10);

        // R4/R5: level mode on pin line 20.
        level[20] = 1'b1;
        pin_n[4] = 1'b0; expect_line(20);
        cyc(3);
        check("R4 level irr set", 64'(irr[20]), 64'd1);
        drain("R4 level activation delivered");
        check("R4 level irr stays while active", 64'(irr[20]), 64'd1);
        pin_n[4] = 1'b1;
        cyc(3);
        check("R4 level irr cleared", 64'(irr[20]), 64'd0);
        cyc(10);
        check("R4 no message on deactivation", 64'(exp_q.size()), 64'd0);
        level[20] = 1'b0;

        // R5: serial source on line 17, pin on line 16.
        ser_n[1] = 1'b0; expect_line(17);
        drain("R5 serial input reaches line 17");
        ser_n[1] = 1'b1; cyc(5);
        pin_n[0] = 1'b0; expect_line(16);
        drain("R5 pin reaches line 16");
        pin_n[0] = 1'b1; cyc(5);

        // R6: virtual wires from PCI messages.
        level[18] = 1'b1;
        intx_msg(2'd2, 1'b1); expect_line(18);
        cyc(1);
        check("R6 INTC assert raises line 18", 64'(irr[18]), 64'd1);
        drain("R6 INTC message delivered");
        intx_msg(2'd2, 1'b0);
        cyc(1);
        check("R6 INTC deassert clears line 18", 64'(irr[18]), 64'd0);
        level[18] = 1'b0;
        intx_msg(2'd3, 1'b1); expect_line(19);
        drain("R6 INTD message delivered on line 19");
        intx_msg(2'd3, 1'b0);
        cyc(5);

        // R10/R11/R12: masked lines collect, then deliver in order.
        ready_lat = 3;
        mask[3] = 1'b1; mask[9] = 1'b1; mask[22] = 1'b1;
        pin_n[6] = 1'b0; direct[9] = 1'b1; direct[3] = 1'b1;
        cyc(4);
        direct[3] = 1'b0; cyc(4); direct[3] = 1'b1;
        cyc(20);
        check("R12 masked irr bits set", 64'({irr[22], irr[9], irr[3]}), 64'b111);
        check("R12 no request while masked", 64'(bus_req), 64'd0);
        expect_line(3); expect_line(9); expect_line(22);
        mask = '0;
        drain("R10 lowest first, R11 single message per line");
        direct[3] = 1'b0; direct[9] = 1'b0; pin_n[6] = 1'b1;
        cyc(10);
        check("R13 all edge bits cleared", 64'(irr), 64'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule